// File: doc/BRIEF.md
# Rate-Scaled Voice Envelope Generator

This block shapes the loudness of one wavetable voice. It holds a 10-bit attenuation value, where 0 is full level and 511 is silence, and moves it through attack, first decay, sustain decay and release phases. A pseudo-reverb tail and a fast damp phase are also provided. Every clock cycle is one output sample. A global envelope counter is shared by all voices and advances once per sample. It decides which samples may update the envelope and how large each step is.

Each 4-bit phase rate is first scaled into a 6-bit effective rate. The scaling uses the voice's signed octave, a rate-correction code and bit 9 of the frequency number, so that higher notes fade faster. Key-on, key-off and damp are single-cycle command pulses, and one instance is used per voice.

Top module: `voice_envelope`

## Requirements
- R1: During and after reset, with no command yet given, `atten` is 511, `active` is 0 and the generator is idle.
- R2: The effective rate is 0 for code 0 and 63 for code 15. When `rate_corr` is 15 it is 4*code. Otherwise it is 2*(signed `octave` + `rate_corr`) + `fnum_b9` + 4*code, clamped to 0..63. `octave` is two's complement, so 4'h8 is -8.
- R3: The envelope changes only in a cycle whose `eg_count` has its low S bits all zero. S is 12 - rate/4 for rates under 48 and 0 otherwise. An effective rate below 4 freezes the envelope.
- R4: The step size is taken from an 8-entry pattern indexed by (`eg_count` >> S) & 7. Rates under 52 use one of four patterns chosen by rate mod 4: 01010101, 01011101, 01110111, 01111111. Rates 52..55 use the same shapes built from 1s and 2s: 11111111, 11121112, 12121212, 12221222. Rates 56..59 double those values. Rates 60..63 step by 4 in decay phases and by 8 in attack.
- R5: In attack, each update lowers the attenuation by ceil((att+1)*step/8). A result of 0 or below clamps to 0 and moves to first decay if `decay_lvl` is nonzero, otherwise to sustain.
- R6: The decay threshold is 16*`decay_lvl`, with code 15 meaning 496. First decay adds the step each update and moves to sustain once the attenuation reaches the threshold.
- R7: In all non-attack phases the attenuation grows by the step and saturates at 511. Reaching 511 in sustain, release, reverb or damp clears `active`.
- R8: With `reverb_en` set, first decay, sustain or release switch to the reverb phase as soon as the attenuation exceeds 96. The reverb phase uses rate code 5 through the R2 scaling.
- R9: `damp` enters the damp phase, which uses a fixed effective rate of 56. It takes priority over `key_on` and `key_off`.
- R10: `key_on` enters attack and sets `active` without changing the attenuation. `key_off` moves an active voice to release unless it is in reverb. A cycle carrying a command performs no envelope update.
- R11: In the idle phase the attenuation never changes until a command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one envelope tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| eg_count | input | 18 | Shared global envelope counter |
| key_on | input | 1 | Start note (pulse) |
| key_off | input | 1 | Release note (pulse) |
| damp | input | 1 | Fast fade (pulse) |
| rate_atk | input | 4 | Attack rate code |
| rate_dec1 | input | 4 | First decay rate code |
| rate_dec2 | input | 4 | Sustain decay rate code |
| rate_rel | input | 4 | Release rate code |
| decay_lvl | input | 4 | First decay end level code |
| rate_corr | input | 4 | Rate correction code, 15 disables scaling |
| octave | input | 4 | Signed octave of the voice |
| fnum_b9 | input | 1 | Frequency number bit 9 |
| reverb_en | input | 1 | Pseudo-reverb enable |
| atten | output | 10 | Attenuation, 0 loudest, 511 silent |
| active | output | 1 | Voice is sounding |

## Verification
The assertions assume that the commands are single-cycle pulses. They also assume that `eg_count` steps by one each cycle, so the update cycles repeat with the period the rate implies. Rate codes and levels are only changed between cycles, never at a clock edge. The stimulus drives all inputs on the falling edge and advances the counter once per cycle. It reprograms the rates only between phases of a scenario, so the reference model sees exactly the values the design registers.

// File: rtl/venv_pkg.sv
package venv_pkg;

   typedef enum logic [2:0] {
      EV_OFF,
      EV_ATTACK,
      EV_DECAY,
      EV_SUSTAIN,
      EV_RELEASE,
      EV_REVERB,
      EV_DAMP
   } env_state_t;

   localparam int CODE_W = 4;
   localparam int RATE_W = 6;
   localparam int STEP_W = 4;

endpackage

// File: rtl/venv_rate_scale.sv
module venv_rate_scale
   import venv_pkg::*;
(
   input  logic [CODE_W-1:0] raw,
   input  logic [CODE_W-1:0] octave,
   input  logic [CODE_W-1:0] corr,
   input  logic              fn9,
   output logic [RATE_W-1:0] rate
);

   localparam int ACC_W    = 9;
   localparam int MAX_RATE = (1 << RATE_W) - 1;

   logic signed [ACC_W-1:0] acc;

   always_comb begin
      acc = ($signed({{(ACC_W-CODE_W){octave[CODE_W-1]}}, octave})
             + $signed({{(ACC_W-CODE_W){1'b0}}, corr})) * 9'sd2
            + $signed({{(ACC_W-1){1'b0}}, fn9})
            + $signed({{(ACC_W-CODE_W-2){1'b0}}, raw, 2'b00});
      if (raw == '0)
         rate = '0;
      else if (raw == '1)
         rate = RATE_W'(MAX_RATE);
      else if (corr == '1)
         rate = {raw, 2'b00};
      else if (acc < 0)
         rate = '0;
      else if (acc > ACC_W'(MAX_RATE))
         rate = RATE_W'(MAX_RATE);
      else
         rate = acc[RATE_W-1:0];
   end

endmodule

// File: rtl/venv_inc_gen.sv
module venv_inc_gen
   import venv_pkg::*;
#(
   parameter int CNT_W = 18
) (
   input  logic [RATE_W-1:0] rate,
   input  logic              attack,
   input  logic [CNT_W-1:0]  count,
   output logic              upd,
   output logic [STEP_W-1:0] inc
);

   localparam int PHASES = 8;

   logic [3:0]               sh;
   logic [CNT_W-1:0]         mask;
   logic [2:0]               phase;
   logic [PHASES*STEP_W-1:0] inc_flat;

   always_comb begin
      sh    = (rate < 6'd48) ? (4'd12 - rate[5:2]) : 4'd0;
      mask  = (CNT_W'(1) << sh) - CNT_W'(1);
      upd   = (count & mask) == '0;
      phase = 3'(count >> sh);
   end

   for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
      localparam bit ODD  = (ph % 2) == 1;
      localparam bit LONZ = (ph % 4) != 0;
      localparam bit LO1  = ODD || (ph == 4);
      localparam bit NZ   = ph != 0;
      localparam bit TOP  = (ph % 4) == 3;
      localparam logic [3:0] LO_SET = {NZ, LONZ, LO1, ODD};
      localparam logic [3:0] HI_SET = {LONZ, ODD, TOP, 1'b0};

      logic [STEP_W-1:0] val;

      always_comb begin
         if (rate < 6'd52)
            val = LO_SET[rate[1:0]] ? 4'd1 : 4'd0;
         else if (rate < 6'd56)
            val = HI_SET[rate[1:0]] ? 4'd2 : 4'd1;
         else if (rate < 6'd60)
            val = HI_SET[rate[1:0]] ? 4'd4 : 4'd2;
         else
            val = attack ? 4'd8 : 4'd4;
      end

      assign inc_flat[ph*STEP_W +: STEP_W] = val;
   end

   assign inc = inc_flat[phase*STEP_W +: STEP_W];

endmodule

// File: rtl/voice_envelope.sv
module voice_envelope
   import venv_pkg::*;
#(
   parameter int ATT_W     = 10,
   parameter int CNT_W     = 18,
   parameter int REV_LEVEL = 96,
   parameter int DL_UNIT   = 16,
   parameter int DAMP_RATE = 56,
   parameter int REV_CODE  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] eg_count,
   input  logic             key_on,
   input  logic             key_off,
   input  logic             damp,
   input  logic [3:0]       rate_atk,
   input  logic [3:0]       rate_dec1,
   input  logic [3:0]       rate_dec2,
   input  logic [3:0]       rate_rel,
   input  logic [3:0]       decay_lvl,
   input  logic [3:0]       rate_corr,
   input  logic [3:0]       octave,
   input  logic             fnum_b9,
   input  logic             reverb_en,
   output logic [ATT_W-1:0] atten,
   output logic             active
);

   localparam int MAX_ATT = (1 << (ATT_W - 1)) - 1;
   localparam int SUM_W   = ATT_W + 1;
   localparam int PROD_W  = ATT_W + 5;

   if (CNT_W < 15) begin : g_cnt_chk
      $error("voice_envelope: CNT_W must cover a 12-bit shift plus 3 phase bits");
   end
   if (31 * DL_UNIT > MAX_ATT) begin : g_dl_chk
      $error("voice_envelope: decay level range exceeds attenuation range");
   end
   if (REV_LEVEL >= MAX_ATT) begin : g_rev_chk
      $error("voice_envelope: reverb threshold must lie below silence");
   end
   if (DAMP_RATE > 63 || REV_CODE > 14) begin : g_rate_chk
      $error("voice_envelope: fixed rates out of range");
   end

   env_state_t          st_q, st_d;
   logic [ATT_W-1:0]    att_q, att_d;
   logic                act_q, act_d;

   logic [CODE_W-1:0]   raw_sel;
   logic [RATE_W-1:0]   scaled_rate, eff_rate;
   logic                upd;
   logic [STEP_W-1:0]   inc;
   logic                step_ok, cmd;
   logic [ATT_W-1:0]    dl_thr;
   logic [PROD_W-1:0]   prod, dec;
   logic                atk_zero;
   logic [ATT_W-1:0]    atk_next;
   logic [SUM_W-1:0]    sum;
   logic                at_ceiling;
   logic [ATT_W-1:0]    grown;
   logic                can_reverb;

   always_comb begin
      unique case (st_q)
         EV_ATTACK:  raw_sel = rate_atk;
         EV_DECAY:   raw_sel = rate_dec1;
         EV_SUSTAIN: raw_sel = rate_dec2;
         EV_RELEASE: raw_sel = rate_rel;
         EV_REVERB:  raw_sel = CODE_W'(REV_CODE);
         default:    raw_sel = '0;
      endcase
   end

   venv_rate_scale u_scale (
      .raw    (raw_sel),
      .octave (octave),
      .corr   (rate_corr),
      .fn9    (fnum_b9),
      .rate   (scaled_rate)
   );

   assign eff_rate = (st_q == EV_DAMP) ? RATE_W'(DAMP_RATE) : scaled_rate;

   venv_inc_gen #(.CNT_W(CNT_W)) u_inc (
      .rate   (eff_rate),
      .attack (st_q == EV_ATTACK),
      .count  (eg_count),
      .upd    (upd),
      .inc    (inc)
   );

   always_comb begin
      cmd     = key_on | key_off | damp;
      step_ok = (st_q != EV_OFF) && (eff_rate >= 6'd4) && upd;
      dl_thr  = (decay_lvl == 4'hF) ? ATT_W'(31 * DL_UNIT)
                                    : ATT_W'(32'(decay_lvl) * DL_UNIT);
      prod     = (PROD_W'(att_q) + PROD_W'(1)) * PROD_W'(inc);
      dec      = (prod + PROD_W'(7)) >> 3;
      atk_zero = PROD_W'(att_q) <= dec;
      atk_next = att_q - dec[ATT_W-1:0];
      sum        = SUM_W'(att_q) + SUM_W'(inc);
      at_ceiling = sum >= SUM_W'(MAX_ATT);
      grown      = at_ceiling ? ATT_W'(MAX_ATT) : sum[ATT_W-1:0];
      can_reverb = (st_q == EV_DECAY) || (st_q == EV_SUSTAIN) || (st_q == EV_RELEASE);
   end

   always_comb begin
      st_d  = st_q;
      att_d = att_q;
      act_d = act_q;
      if (damp) begin
         st_d = EV_DAMP;
      end else if (key_on) begin
         st_d  = EV_ATTACK;
         act_d = 1'b1;
      end else if (key_off) begin
         if (act_q && st_q != EV_REVERB)
            st_d = EV_RELEASE;
      end else if (step_ok) begin
         if (st_q == EV_ATTACK) begin
            if (atk_zero) begin
               att_d = '0;
               st_d  = (decay_lvl != '0) ? EV_DECAY : EV_SUSTAIN;
            end else begin
               att_d = atk_next;
            end
         end else begin
            att_d = grown;
            if (reverb_en && can_reverb && grown > ATT_W'(REV_LEVEL))
               st_d = EV_REVERB;
            else if (st_q == EV_DECAY) begin
               if (grown >= dl_thr)
                  st_d = EV_SUSTAIN;
            end else if (at_ceiling)
               act_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= EV_OFF;
         att_q <= ATT_W'(MAX_ATT);
         act_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         att_q <= att_d;
         act_q <= act_d;
      end
   end

   assign atten  = att_q;
   assign active = act_q;

   AST_ATT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      atten <= ATT_W'(MAX_ATT)); // R7
   AST_SILENT_AT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> atten == ATT_W'(MAX_ATT)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd || cmd || eff_rate < 6'd4) |=> $stable(atten)); // R3
   AST_KEYON_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
      (key_on && !damp) |=> (st_q == EV_ATTACK) && active); // R10
   AST_DAMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      damp |=> st_q == EV_DAMP); // R9
   AST_REVERB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == EV_REVERB && key_off && !key_on && !damp) |=> st_q == EV_REVERB); // R8
   AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == EV_OFF && !key_on && !damp) |=> (st_q == EV_OFF) && $stable(atten)); // R11
   AST_ATTACK_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == EV_ATTACK && !cmd) |=> atten <= $past(atten)); // R5

endmodule

// File: tb/voice_envelope_test.sv
module voice_envelope_test;

   localparam int CW = 18;
   localparam int S_OFF = 0, S_ATK = 1, S_DEC = 2, S_SUS = 3, S_REL = 4, S_REV = 5, S_DMP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] eg_count = '0;
   logic          key_on = 1'b0, key_off = 1'b0, damp = 1'b0;
   logic [3:0]    rate_atk = '0, rate_dec1 = '0, rate_dec2 = '0, rate_rel = '0;
   logic [3:0]    decay_lvl = '0, rate_corr = '0, octave = '0;
   logic          fnum_b9 = 1'b0, reverb_en = 1'b0;
   logic [9:0]    atten;
   logic          active;

   always #2 clk = ~clk;

   voice_envelope uut (
      .clk(clk), .rst_n(rst_n), .eg_count(eg_count),
      .key_on(key_on), .key_off(key_off), .damp(damp),
      .rate_atk(rate_atk), .rate_dec1(rate_dec1), .rate_dec2(rate_dec2),
      .rate_rel(rate_rel), .decay_lvl(decay_lvl), .rate_corr(rate_corr),
      .octave(octave), .fnum_b9(fnum_b9), .reverb_en(reverb_en),
      .atten(atten), .active(active)
   );

   int unsigned rows [15] = '{32'h01010101, 32'h01011101, 32'h01110111, 32'h01111111,
                              32'h11111111, 32'h11121112, 32'h12121212, 32'h12221222,
                              32'h22222222, 32'h22242224, 32'h24242424, 32'h24442444,
                              32'h44444444, 32'h88888888, 32'h0};

   int          m_att = 511, m_act = 0, m_st = S_OFF;
   int unsigned cnt = 0;
   int          vectors = 0, miscompares = 0;
   bit          done = 1'b0;
   string       tag = "R1 reset";

   function automatic int eff(input int raw);
      int so, r;
      if (raw == 0) return 0;
      if (raw == 15) return 63;
      if (rate_corr == 15) return raw * 4;
      so = (octave >= 8) ? int'(octave) - 16 : int'(octave);
      r = (so + int'(rate_corr)) * 2 + int'(fnum_b9) + raw * 4;
      if (r < 0) r = 0;
      if (r > 63) r = 63;
      return r;
   endfunction

   task automatic model_step(input bit kon, input bit koff, input bit dmp);
      int rate, sh, row, idx, inc, n, c, dlv;
      c = int'(cnt % (1 << CW));
      if (dmp) begin
         m_st = S_DMP;
         return;
      end
      if (kon) begin
         m_st = S_ATK; m_act = 1;
         return;
      end
      if (koff) begin
         if (m_act == 1 && m_st != S_REV) m_st = S_REL;
         return;
      end
      case (m_st)
         S_ATK: rate = eff(rate_atk);
         S_DEC: rate = eff(rate_dec1);
         S_SUS: rate = eff(rate_dec2);
         S_REL: rate = eff(rate_rel);
         S_REV: rate = eff(5);
         S_DMP: rate = 56;
         default: return;
      endcase
      if (rate < 4) return;
      sh = (rate < 48) ? 12 - rate / 4 : 0;
      if (c % (1 << sh) != 0) return;
      if (rate < 52) row = rate % 4;
      else if (rate < 56) row = 4 + rate % 4;
      else if (rate < 60) row = 8 + rate % 4;
      else row = (m_st == S_ATK) ? 13 : 12;
      idx = (c >> sh) & 7;
      inc = int'((rows[row] >> (4 * (7 - idx))) & 15);
      if (m_st == S_ATK) begin
         n = m_att - ((m_att + 1) * inc + 7) / 8;
         if (n <= 0) begin
            m_att = 0;
            m_st = (decay_lvl != 0) ? S_DEC : S_SUS;
         end else m_att = n;
      end else begin
         dlv = (decay_lvl == 15) ? 496 : 16 * int'(decay_lvl);
         n = m_att + inc;
         if (n > 511) n = 511;
         m_att = n;
         if (reverb_en && n > 96 && (m_st == S_DEC || m_st == S_SUS || m_st == S_REL))
            m_st = S_REV;
         else if (m_st == S_DEC) begin
            if (n >= dlv) m_st = S_SUS;
         end else if (n >= 511) m_act = 0;
      end
   endtask

   task automatic compare();
      vectors++;
      if (atten !== 10'(m_att) || active !== 1'(m_act)) begin
         miscompares++;
         $display("FAIL %s: atten=%0d active=%0d expected atten=%0d active=%0d",
                  tag, atten, active, m_att, m_act);
      end
   endtask

   task automatic cycle(input bit kon, input bit koff, input bit dmp);
      @(negedge clk);
      cnt++;
      eg_count = CW'(cnt);
      key_on = kon; key_off = koff; damp = dmp;
      model_step(kon, koff, dmp);
      @(posedge clk);
      #1;
      compare();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      tag = "R1 reset";
      compare();
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare();

      tag = "R11 idle hold";
      run(20);
      cycle(1'b0, 1'b1, 1'b0);
      run(5);

      tag = "R5 R6 R7 R4 fast attack, decay, sustain to silence";
      rate_atk = 4'hF; decay_lvl = 4'd3; rate_dec1 = 4'd12; rate_dec2 = 4'd13;
      cycle(1'b1, 1'b0, 1'b0);
      run(700);

      tag = "R2 R3 R10 scaled attack, frozen sustain, release";
      rate_atk = 4'd10; octave = 4'd3; rate_corr = 4'd2; fnum_b9 = 1'b1;
      decay_lvl = 4'd0; rate_dec2 = 4'd0; rate_rel = 4'd14;
      cycle(1'b1, 1'b0, 1'b0);
      run(300);
      cycle(1'b0, 1'b1, 1'b0);
      run(200);

      tag = "R2 R4 R6 negative octave, slow decay to level 15";
      octave = 4'hC; rate_corr = 4'd3; fnum_b9 = 1'b0;
      rate_atk = 4'd12; decay_lvl = 4'hF; rate_dec1 = 4'd11; rate_rel = 4'hF;
      cycle(1'b1, 1'b0, 1'b0);
      run(40);
      cycle(1'b0, 1'b1, 1'b0);
      run(20);
      cycle(1'b1, 1'b0, 1'b0);
      run(3000);
      cycle(1'b0, 1'b1, 1'b0);
      run(200);

      tag = "R8 R10 pseudo-reverb entry and ignored key-off";
      reverb_en = 1'b1; octave = 4'd7; rate_corr = 4'd14; fnum_b9 = 1'b1;
      rate_atk = 4'hF; decay_lvl = 4'd10; rate_dec1 = 4'd14;
      cycle(1'b1, 1'b0, 1'b0);
      run(40);
      cycle(1'b0, 1'b1, 1'b0);
      run(200);
      reverb_en = 1'b0;

      tag = "R9 damp from slow attack";
      octave = 4'd0; rate_corr = 4'd0; fnum_b9 = 1'b0; rate_atk = 4'd1;
      cycle(1'b1, 1'b0, 1'b0);
      run(30);
      cycle(1'b0, 1'b0, 1'b1);
      run(300);
      tag = "R9 damp wins over key-on";
      @(negedge clk);
      cnt++;
      eg_count = CW'(cnt);
      key_on = 1'b1; damp = 1'b1; key_off = 1'b0;
      model_step(1'b0, 1'b0, 1'b1);
      @(posedge clk);
      #1;
      compare();
      run(5);

      tag = "R3 R2 clamped-to-zero rate freezes, then corrected rate";
      rate_atk = 4'd2; octave = 4'h8; rate_corr = 4'd0;
      cycle(1'b1, 1'b0, 1'b0);
      run(50);
      rate_corr = 4'hF;
      run(4200);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule